// File: doc/BRIEF.md
# Double-Buffered Divider Programming Registers

This block is the parallel programming front end of a frequency synthesizer's divider chain. An 8-bit data bus can be written into three primary byte sections. Each section has its own write strobe. The first section holds the low byte of the main divide value. The second holds the top bit of the main divide value and the six-bit reference divide value. The third holds the four-bit swallow count.

A hop strobe copies all three primary sections into a secondary bank in a single clock cycle. A select input then decides which bank drives the divider outputs. Software can prepare the next channel in one bank while the other bank is in use, and a single select toggle switches between the two frequencies. A separate 8-bit enhancement register is loaded from the same bus through its own strobe. Its bits reach the outputs only while an active-low enable is asserted.

All strobes are asynchronous to the system clock. Each strobe passes through a two-flop synchronizer and an edge detector. Writes of any kind happen only when both mode-select inputs are low.

Top module: `hop_reg_bank`

## Requirements
- R1: After reset, the primary sections, the secondary bank and the enhancement register are all zero. With either select value and the enhancement enable asserted, every output reads zero.
- R2: A rising edge on `wr_m_lo` stores `din` in primary section 0. This section supplies `div_m[7:0]`.
- R3: A rising edge on `wr_m_hi` stores `din` in primary section 1. Bit 0 of this section drives `div_m[8]`, bits 6:1 drive `div_r[5:0]`, and bit 7 is unused.
- R4: A rising edge on `wr_swal` stores `din` in primary section 2. Bits 3:0 of this section drive `div_a`, and bits 7:4 are unused.
- R5: A rising edge on `wr_hop` copies all three primary sections into the secondary bank at the same clock edge. Later primary writes leave the secondary bank unchanged until the next hop.
- R6: While `use_primary` is 1, the divider outputs show the primary sections. While it is 0, they show the secondary bank. The outputs follow the select combinationally.
- R7: A rising edge on `wr_enh` stores `din` in the enhancement register. `enh_ctrl` equals that register while `enh_en_n` is 0, and reads all zero while `enh_en_n` is 1.
- R8: A strobe edge that arrives while `mode_bus` or `mode_ser` is 1 has no effect. This holds for section writes, enhancement writes and hop transfers alike.
- R9: Each rising edge of a strobe causes exactly one write. If the strobe is held high and `din` then changes, the stored value does not change.
- R10: A strobe that rises between two clock edges has its write visible at the outputs after the third following rising clock edge, and not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_bus | input | 1 | Mode select; parallel writes need 0 |
| mode_ser | input | 1 | Mode select; parallel writes need 0 |
| din | input | 8 | Parallel data byte |
| wr_m_lo | input | 1 | Write strobe for primary section 0 |
| wr_m_hi | input | 1 | Write strobe for primary section 1 |
| wr_swal | input | 1 | Write strobe for primary section 2 |
| wr_hop | input | 1 | Primary-to-secondary transfer strobe |
| wr_enh | input | 1 | Enhancement register write strobe |
| use_primary | input | 1 | 1 selects primary, 0 selects secondary |
| enh_en_n | input | 1 | Active-low enhancement enable |
| div_m | output | 9 | Main divide value |
| div_r | output | 6 | Reference divide value |
| div_a | output | 4 | Swallow count |
| enh_ctrl | output | 8 | Gated enhancement control bits |

## Verification
A corrupted primary section is visible at the divider outputs as soon as the select is high, without any clock edge. A corrupted secondary bank only appears once the select goes low, so the bench reads both banks after every operation. A synchronizer or edge detector that fires twice, or never, shows up as a wrong value three clock edges after the strobe. It is also caught when data changes while a strobe is held high. A mode gate that leaks lets a blocked write change the outputs right after the same latency.

// File: rtl/hop_reg_pkg.sv
package hop_reg_pkg;
  localparam int DATA_W   = 8;
  localparam int M_W      = 9;
  localparam int R_W      = 6;
  localparam int A_W      = 4;
  localparam int SYNC_LEN = 2;

  localparam int STB_M_LO = 0;
  localparam int STB_M_HI = 1;
  localparam int STB_SWAL = 2;
  localparam int STB_HOP  = 3;
  localparam int STB_ENH  = 4;
  localparam int STB_NUM  = 5;

  typedef struct packed {
    logic [DATA_W-1:0] swal;
    logic [DATA_W-1:0] m_hi;
    logic [DATA_W-1:0] m_lo;
  } sect_bank_t;

  function automatic logic [M_W-1:0] field_m(input sect_bank_t b);
    return {b.m_hi[0], b.m_lo};
  endfunction

  function automatic logic [R_W-1:0] field_r(input sect_bank_t b);
    return b.m_hi[R_W:1];
  endfunction

  function automatic logic [A_W-1:0] field_a(input sect_bank_t b);
    return b.swal[A_W-1:0];
  endfunction
endpackage

// File: rtl/hop_strobe_sync.sv
module hop_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_in,
  output logic rise_pulse
);
  logic [STAGES:0] shift_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= {shift_q[STAGES-1:0], strobe_in};
  end

  assign rise_pulse = shift_q[STAGES-1] & ~shift_q[STAGES];
endmodule

// File: rtl/hop_reg_store.sv
module hop_reg_store
  import hop_reg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              par_mode,
  input  logic [STB_NUM-1:0] rise_vec,
  input  logic [DATA_W-1:0] din,
  output sect_bank_t        prim_q,
  output sect_bank_t        sec_q,
  output logic [DATA_W-1:0] enh_q
);
  logic [STB_NUM-1:0] wr_ok;
  assign wr_ok = par_mode ? rise_vec : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prim_q <= '0;
    end else begin
      if (wr_ok[STB_M_LO]) prim_q.m_lo <= din;
      if (wr_ok[STB_M_HI]) prim_q.m_hi <= din;
      if (wr_ok[STB_SWAL]) prim_q.swal <= din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                sec_q <= '0;
    else if (wr_ok[STB_HOP])   sec_q <= prim_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                enh_q <= '0;
    else if (wr_ok[STB_ENH])   enh_q <= din;
  end
endmodule

// File: rtl/hop_out_sel.sv
module hop_out_sel
  import hop_reg_pkg::*;
(
  input  sect_bank_t        prim_q,
  input  sect_bank_t        sec_q,
  input  logic [DATA_W-1:0] enh_q,
  input  logic              use_primary,
  input  logic              enh_en_n,
  output logic [M_W-1:0]    div_m,
  output logic [R_W-1:0]    div_r,
  output logic [A_W-1:0]    div_a,
  output logic [DATA_W-1:0] enh_ctrl
);
  sect_bank_t live;

  always_comb begin
    live     = use_primary ? prim_q : sec_q;
    div_m    = field_m(live);
    div_r    = field_r(live);
    div_a    = field_a(live);
    enh_ctrl = enh_en_n ? '0 : enh_q;
  end
endmodule

// File: rtl/hop_reg_bank.sv
module hop_reg_bank
  import hop_reg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_bus,
  input  logic              mode_ser,
  input  logic [DATA_W-1:0] din,
  input  logic              wr_m_lo,
  input  logic              wr_m_hi,
  input  logic              wr_swal,
  input  logic              wr_hop,
  input  logic              wr_enh,
  input  logic              use_primary,
  input  logic              enh_en_n,
  output logic [M_W-1:0]    div_m,
  output logic [R_W-1:0]    div_r,
  output logic [A_W-1:0]    div_a,
  output logic [DATA_W-1:0] enh_ctrl
);
  logic [STB_NUM-1:0] strobe_vec;
  logic [STB_NUM-1:0] rise_vec;
  logic               par_mode;
  sect_bank_t         prim_q;
  sect_bank_t         sec_q;
  logic [DATA_W-1:0]  enh_q;

  assign strobe_vec = {wr_enh, wr_hop, wr_swal, wr_m_hi, wr_m_lo};
  assign par_mode   = ~mode_bus & ~mode_ser;

  for (genvar i = 0; i < STB_NUM; i++) begin : g_sync
    hop_strobe_sync #(.STAGES(SYNC_LEN)) u_sync (
      .clk        (clk),
      .rst_n      (rst_n),
      .strobe_in  (strobe_vec[i]),
      .rise_pulse (rise_vec[i])
    );
  end

  hop_reg_store u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .par_mode (par_mode),
    .rise_vec (rise_vec),
    .din      (din),
    .prim_q   (prim_q),
    .sec_q    (sec_q),
    .enh_q    (enh_q)
  );

  hop_out_sel u_out (
    .prim_q      (prim_q),
    .sec_q       (sec_q),
    .enh_q       (enh_q),
    .use_primary (use_primary),
    .enh_en_n    (enh_en_n),
    .div_m       (div_m),
    .div_r       (div_r),
    .div_a       (div_a),
    .enh_ctrl    (enh_ctrl)
  );
endmodule

// File: rtl/hop_reg_bank_chk.sv
module hop_reg_bank_chk
  import hop_reg_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               par_mode,
  input logic [STB_NUM-1:0] rise_vec,
  input sect_bank_t         prim_q,
  input sect_bank_t         sec_q,
  input logic [DATA_W-1:0]  enh_q,
  input logic               enh_en_n,
  input logic [DATA_W-1:0]  enh_ctrl
);
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_vec != '0) |=> ((rise_vec & $past(rise_vec)) == '0)); // R9

  AST_MODE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !par_mode |=> ($stable(prim_q) && $stable(sec_q) && $stable(enh_q))); // R8

  AST_HOP_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (par_mode && rise_vec[STB_HOP]) |=> (sec_q == $past(prim_q))); // R5

  AST_SEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rise_vec[STB_HOP] |=> $stable(sec_q)); // R5

  AST_ENH_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (!enh_en_n |-> enh_ctrl == enh_q) and (enh_en_n |-> enh_ctrl == '0)); // R7
endmodule

bind hop_reg_bank hop_reg_bank_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .par_mode (par_mode),
  .rise_vec (rise_vec),
  .prim_q   (prim_q),
  .sec_q    (sec_q),
  .enh_q    (enh_q),
  .enh_en_n (enh_en_n),
  .enh_ctrl (enh_ctrl)
);

// File: tb/tb_hop_reg_bank.sv
module tb_hop_reg_bank;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_bus = 1'b0, mode_ser = 1'b0;
  logic [7:0] din = '0;
  logic       wr_m_lo = 0, wr_m_hi = 0, wr_swal = 0, wr_hop = 0, wr_enh = 0;
  logic       use_primary = 1'b1, enh_en_n = 1'b0;
  logic [8:0] div_m;
  logic [5:0] div_r;
  logic [3:0] div_a;
  logic [7:0] enh_ctrl;

  int n_chk = 0, n_bad = 0;
  logic [7:0] e_p [3];
  logic [7:0] e_s [3];
  logic [7:0] e_e;

  always #4 clk = ~clk;

  hop_reg_bank dut (.*);

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  function automatic logic [8:0] exp_m(input logic [7:0] lo, input logic [7:0] hi);
    return {hi[0], lo};
  endfunction
  function automatic logic [5:0] exp_r(input logic [7:0] hi);
    return hi[6:1];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    use_primary = 1'b1; enh_en_n = 1'b0; #1;
    chk({req, " R6 prim M"}, div_m, exp_m(e_p[0], e_p[1]));
    chk({req, " R3 prim R"}, div_r, exp_r(e_p[1]));
    chk({req, " R4 prim A"}, div_a, e_p[2][3:0]);
    chk({req, " R7 enh on"}, enh_ctrl, e_e);
    use_primary = 1'b0; enh_en_n = 1'b1; #1;
    chk({req, " R5 sec M"}, div_m, exp_m(e_s[0], e_s[1]));
    chk({req, " R5 sec R"}, div_r, exp_r(e_s[1]));
    chk({req, " R5 sec A"}, div_a, e_s[2][3:0]);
    chk({req, " R7 enh off"}, enh_ctrl, 8'h00);
  endtask

  task automatic set_stb(input int k, input logic v);
    case (k)
      0: wr_m_lo = v;
      1: wr_m_hi = v;
      2: wr_swal = v;
      3: wr_hop  = v;
      default: wr_enh = v;
    endcase
  endtask

  task automatic do_write(input int k, input logic [7:0] d, input logic gate_ok);
    @(negedge clk);
    din = d;
    set_stb(k, 1'b1);
    repeat (4) @(negedge clk);
    set_stb(k, 1'b0);
    repeat (4) @(negedge clk);
    if (gate_ok) begin
      if (k < 3) e_p[k] = d;
      else if (k == 3) e_s = e_p;
      else e_e = d;
    end
  endtask

  initial begin
    int unused;
    unused = $urandom(32'h5eed_1234);
    for (int i = 0; i < 3; i++) begin e_p[i] = '0; e_s[i] = '0; end
    e_e = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 reset");

    do_write(0, 8'hA5, 1'b1); check_all("R2 m_lo");
    do_write(1, 8'hFF, 1'b1); check_all("R3 m_hi all ones");
    do_write(2, 8'hF7, 1'b1); check_all("R4 swal upper ignored");
    do_write(3, 8'h00, 1'b1); check_all("R5 hop");
    do_write(0, 8'h3C, 1'b1); check_all("R5 sec holds after primary write");
    do_write(4, 8'h96, 1'b1); check_all("R7 enh");

    // R8: mode gating, each mode input alone
    mode_bus = 1'b1;
    do_write(0, 8'h11, 1'b0); do_write(3, 8'h00, 1'b0); check_all("R8 mode_bus blocks");
    mode_bus = 1'b0; mode_ser = 1'b1;
    do_write(4, 8'h22, 1'b0); do_write(2, 8'h0E, 1'b0); check_all("R8 mode_ser blocks");
    mode_ser = 1'b0;

    // R10: latency, strobe rises mid-cycle
    use_primary = 1'b1;
    @(negedge clk);
    din = 8'h5A; wr_m_lo = 1'b1;
    repeat (2) @(posedge clk);
    #2 chk("R10 not after 2 edges", div_m[7:0], e_p[0]);
    @(posedge clk);
    #2 chk("R10 visible after 3 edges", div_m[7:0], 8'h5A);
    e_p[0] = 8'h5A;
    // R9: data change while strobe held high
    repeat (3) @(negedge clk);
    din = 8'hC3;
    repeat (5) @(negedge clk);
    chk("R9 held strobe no rewrite", div_m[7:0], 8'h5A);
    wr_m_lo = 1'b0;
    repeat (4) @(negedge clk);
    check_all("R9 after release");

    // random mix
    for (int n = 0; n < 150; n++) begin
      int k;
      logic blk;
      k = int'($urandom_range(0, 4));
      blk = ($urandom_range(0, 5) == 0);
      mode_bus = blk & $urandom_range(0, 1);
      mode_ser = blk & ~mode_bus;
      do_write(k, 8'($urandom()), ~(mode_bus | mode_ser));
      mode_bus = 1'b0; mode_ser = 1'b0;
      check_all("random R2 R5 R8");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule